// File: doc/BRIEF.md
# Strobed write-burst receiver

This block is the device end of a parallel write burst in which the host clocks 16-bit words across the cable by toggling a strobe line. Every change of the strobe level, rising or falling, carries one word. The receiver resynchronises the strobe and data into its own clock domain, detects each level change and pushes the matching word into a local FIFO. Downstream logic reads the FIFO through a show-ahead pop port.

The receiver owns the burst request line and an active-low ready line. It raises the request when the core wants data. It holds ready low while the FIFO has room. It raises ready (pause) once free space shrinks to a headroom threshold, so that words already on the way still fit. A burst ends in one of two ways. The core can withdraw its want, which pauses the burst, runs a minimum pause interval and then drops the request. The host can instead raise its halt line, which drops the request at once.

Strobe and halt count only while both the request and the host acknowledge are asserted. Once the acknowledge falls after the end of a burst, the block publishes how many words that burst delivered.

Top module: `strobe_burst_rx`

## Requirements
- R1: After reset, burst_req_o is 0, rdy_n_o is 1, pop_valid_o is 0, tally_o is 0 and tally_vld_o is 0.
- R2: When idle with xfer_want_i high, burst_req_o rises one cycle later. rdy_n_o stays 1 until host_ack_i has been high for 3 cycles (two synchroniser stages plus the state register), and it goes low in that third cycle.
- R3: While a burst is active, every change of the wr_strobe_i level captures wr_data_i. Rising and falling changes both count. The word becomes visible at the pop port 3 cycles after the change.
- R4: The FIFO returns words in arrival order. pop_data_o shows the oldest word while pop_valid_o is 1, and a cycle with pop_i high removes it.
- R5: During a burst, rdy_n_o is 1 whenever free FIFO space (FIFO_DEPTH minus stored words) is at most HEADROOM (3). It returns to 0 as soon as free space exceeds HEADROOM again.
- R6: Words that arrive after rdy_n_o has risen are stored without loss. With the defaults, two such words fit after a pause caused by free space reaching 3.
- R7: Strobe changes and halt requests are ignored unless burst_req_o and the synchronised acknowledge are both high. This covers the idle state and the time after burst_req_o has fallen. An acknowledge with xfer_want_i low does not raise burst_req_o.
- R8: When xfer_want_i falls during a burst, rdy_n_o rises one cycle later. burst_req_o falls exactly TRP_CYC cycles after that rise, and never earlier.
- R9: A rise of host_halt_i during an active burst makes burst_req_o fall 3 cycles later, without the pause interval.
- R10: When host_ack_i falls after a burst has ended, tally_o takes the number of words captured in that burst, and tally_vld_o pulses for one cycle. Both appear 3 cycles after the acknowledge falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_want_i | input | 1 | Core wants a burst (level) |
| host_ack_i | input | 1 | Host acknowledge of the burst request (asynchronous) |
| host_halt_i | input | 1 | Host request to end the burst (asynchronous) |
| wr_strobe_i | input | 1 | Host data strobe; each level change carries a word |
| wr_data_i | input | DATA_W | Host write data |
| burst_req_o | output | 1 | Burst request to the host |
| rdy_n_o | output | 1 | Active-low ready; 1 asks the host to pause |
| pop_i | input | 1 | Remove the oldest FIFO word |
| pop_valid_o | output | 1 | FIFO holds at least one word |
| pop_data_o | output | DATA_W | Oldest FIFO word |
| tally_o | output | TALLY_W | Word count of the last finished burst |
| tally_vld_o | output | 1 | One-cycle pulse when tally_o is updated |

## Verification
Every host input passes two synchroniser flops before the state register or the FIFO reacts to it. A captured word, a ready change after an acknowledge, a halt and a published tally are therefore each due exactly 3 cycles after the stimulus. Pause and FIFO-level effects follow 1 cycle after their cause. The bench drives inputs on the falling clock edge and samples on later falling edges. It checks the cycle before each due cycle, where the old value must still hold, and the due cycle itself, where the new value must appear. The pause interval is checked one cycle short of TRP_CYC and exactly at TRP_CYC, in a sweep of burst lengths 1 to 4.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_XFER,
    ST_PAUSE,
    ST_END
  } rx_state_e;

  // Free FIFO slots given depth and occupancy.
  function automatic int free_slots(int depth, int used);
    return depth - used;
  endfunction

  // Pause is needed when the space left is no more than the headroom.
  function automatic logic must_pause(int free_n, int room);
    return free_n <= room;
  endfunction

endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[i] <= '0;
      else if (i == 0) stg[i] <= d_i;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sbr_fifo.sv
module sbr_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [DW-1:0]    push_data_i,
  input  logic             pop_i,
  output logic [DW-1:0]    pop_data_o,
  output logic [CNT_W-1:0] used_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic do_push, do_pop;

  assign full_o  = used_o == CNT_W'(DEPTH);
  assign empty_o = used_o == '0;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used_o <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   used_o <= used_o + 1'b1;
        2'b01:   used_o <= used_o - 1'b1;
        default: used_o <= used_o;
      endcase
    end
  end

  assign pop_data_o = mem[rd_ptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o); // R6
  AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o) |=> used_o == $past(used_o) - 1'b1); // R4
endmodule

// File: rtl/sbr_ctrl.sv
module sbr_ctrl
  import sbr_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int HEADROOM = 3,
  parameter int TRP_CYC  = 5,
  parameter int TALLY_W  = 16,
  localparam int CNT_W   = $clog2(DEPTH+1),
  localparam int TRP_W   = $clog2(TRP_CYC+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               want_i,
  input  logic               ack_s_i,
  input  logic               halt_s_i,
  input  logic               cap_evt_i,
  input  logic [CNT_W-1:0]   used_i,
  output logic               burst_req_o,
  output logic               rdy_n_o,
  output logic               active_o,
  output logic [TALLY_W-1:0] tally_o,
  output logic               tally_vld_o
);
  localparam logic [TRP_W-1:0] TRP_LAST = TRP_W'(TRP_CYC - 1);
  localparam logic [TRP_W-1:0] RUN_MAX  = TRP_W'(TRP_CYC);

  rx_state_e          state, state_d;
  logic [TRP_W-1:0]   trp_cnt;
  logic [TALLY_W-1:0] words_q;
  logic               low_room;
  logic               burst_start;
  logic               burst_close;

  assign low_room    = must_pause(free_slots(DEPTH, int'(used_i)), HEADROOM);
  assign burst_start = (state == ST_REQ) && ack_s_i;
  assign burst_close = (state == ST_END) && !ack_s_i;

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE:  if (want_i && !low_room) state_d = ST_REQ;
      ST_REQ:   if (ack_s_i) state_d = ST_XFER;
      ST_XFER:  if (halt_s_i) state_d = ST_END;
                else if (!want_i) state_d = ST_PAUSE;
      ST_PAUSE: if (halt_s_i || trp_cnt == TRP_LAST) state_d = ST_END;
      ST_END:   if (!ack_s_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      trp_cnt     <= '0;
      words_q     <= '0;
      tally_o     <= '0;
      tally_vld_o <= 1'b0;
    end else begin
      state       <= state_d;
      trp_cnt     <= (state == ST_PAUSE) ? trp_cnt + 1'b1 : '0;
      tally_vld_o <= burst_close;
      if (burst_start)    words_q <= '0;
      else if (cap_evt_i) words_q <= words_q + 1'b1;
      if (burst_close)    tally_o <= words_q;
    end
  end

  assign burst_req_o = (state == ST_REQ) || (state == ST_XFER) || (state == ST_PAUSE);
  assign active_o    = ((state == ST_XFER) || (state == ST_PAUSE)) && ack_s_i;
  assign rdy_n_o     = !((state == ST_XFER) && !low_room);

  // Cycles of continuous pause while requesting, saturated.
  logic [TRP_W-1:0] rdy_run;
  always_ff @(posedge clk) begin
    if (!rst_n) rdy_run <= '0;
    else if (rdy_n_o && burst_req_o) rdy_run <= (rdy_run == RUN_MAX) ? rdy_run : rdy_run + 1'b1;
    else rdy_run <= '0;
  end

  AST_TRP_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(burst_req_o) && !$past(halt_s_i)) |-> (32'($past(rdy_run)) + 1 >= TRP_CYC)); // R8
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |=> $stable(words_q)); // R7
  AST_HALT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_s_i && active_o) |=> !burst_req_o); // R9
  AST_TALLY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tally_vld_o |=> !tally_vld_o); // R10
endmodule

// File: rtl/strobe_burst_rx.sv
module strobe_burst_rx #(
  parameter int DATA_W      = 16,
  parameter int FIFO_DEPTH  = 8,
  parameter int HEADROOM    = 3,
  parameter int TRP_CYC     = 5,
  parameter int TALLY_W     = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(FIFO_DEPTH+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_want_i,
  input  logic               host_ack_i,
  input  logic               host_halt_i,
  input  logic               wr_strobe_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic               burst_req_o,
  output logic               rdy_n_o,
  input  logic               pop_i,
  output logic               pop_valid_o,
  output logic [DATA_W-1:0]  pop_data_o,
  output logic [TALLY_W-1:0] tally_o,
  output logic               tally_vld_o
);
  logic [2:0]        ctl_s;
  logic [DATA_W-1:0] data_s;
  logic              ack_s, halt_s, stb_s, stb_q;
  logic              active, cap_evt;
  logic [CNT_W-1:0]  used;
  logic              fifo_full, fifo_empty;

  sbr_sync #(.W(3), .STAGES(SYNC_STAGES)) i_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({host_ack_i, host_halt_i, wr_strobe_i}), .q_o(ctl_s));

  sbr_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) i_dat_sync (
    .clk(clk), .rst_n(rst_n), .d_i(wr_data_i), .q_o(data_s));

  assign {ack_s, halt_s, stb_s} = ctl_s;

  always_ff @(posedge clk) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_s;
  end

  assign cap_evt = active && (stb_s ^ stb_q);

  sbr_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_i(cap_evt), .push_data_i(data_s),
    .pop_i(pop_i), .pop_data_o(pop_data_o),
    .used_o(used), .full_o(fifo_full), .empty_o(fifo_empty));

  sbr_ctrl #(.DEPTH(FIFO_DEPTH), .HEADROOM(HEADROOM), .TRP_CYC(TRP_CYC),
             .TALLY_W(TALLY_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .want_i(xfer_want_i), .ack_s_i(ack_s), .halt_s_i(halt_s),
    .cap_evt_i(cap_evt), .used_i(used),
    .burst_req_o(burst_req_o), .rdy_n_o(rdy_n_o), .active_o(active),
    .tally_o(tally_o), .tally_vld_o(tally_vld_o));

  assign pop_valid_o = !fifo_empty;

  AST_READY_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n_o |-> !fifo_full); // R5
  AST_NO_CAPTURE_UNREQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_req_o |=> $stable(used) || $past(pop_i)); // R7
endmodule

// File: tb/test_strobe_burst_rx.sv
module test_strobe_burst_rx;
  localparam int DW = 16;
  localparam int TRP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic want = 1'b0, ack = 1'b0, halt = 1'b0, stb = 1'b0, pop = 1'b0;
  logic [DW-1:0] data = '0;
  logic req, rdy_n, pvld, tvld;
  logic [DW-1:0] pdata, tally;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  strobe_burst_rx #(.DATA_W(DW), .FIFO_DEPTH(8), .HEADROOM(3), .TRP_CYC(TRP),
                    .TALLY_W(16), .SYNC_STAGES(2)) i_strobe_burst_rx (
    .clk(clk), .rst_n(rst_n), .xfer_want_i(want), .host_ack_i(ack),
    .host_halt_i(halt), .wr_strobe_i(stb), .wr_data_i(data),
    .burst_req_o(req), .rdy_n_o(rdy_n), .pop_i(pop), .pop_valid_o(pvld),
    .pop_data_o(pdata), .tally_o(tally), .tally_vld_o(tvld));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic eq(input string rq, input int act, input int exp);
    chk(act == exp, rq, act, exp);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [DW-1:0] v);
    stb  = ~stb;
    data = v;
  endtask

  task automatic pop_expect(input string rq, input logic [DW-1:0] v);
    eq({rq, " valid"}, int'(pvld), 1);
    eq({rq, " data"}, int'(pdata), int'(v));
    pop = 1'b1;
    tick(1);
    pop = 1'b0;
  endtask

  function automatic logic [DW-1:0] wfill(input int k);
    return DW'(16'hC3A0 ^ (k * 16'h0F01));
  endfunction

  function automatic logic [DW-1:0] wsweep(input int len, input int k);
    return DW'((len << 12) | (k * 37 + 5));
  endfunction

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    tick(3);
    // R1 reset state
    eq("R1 req", int'(req), 0);
    eq("R1 rdy_n", int'(rdy_n), 1);
    eq("R1 pop_valid", int'(pvld), 0);
    eq("R1 tally", int'(tally), 0);
    eq("R1 tally_vld", int'(tvld), 0);
    rst_n = 1'b1;
    tick(1);

    // R7 strobe, halt and acknowledge while idle are ignored
    send(16'h1111);
    halt = 1'b1;
    ack  = 1'b1;
    tick(4);
    eq("R7 idle strobe pop_valid", int'(pvld), 0);
    eq("R7 idle ack req", int'(req), 0);
    halt = 1'b0;
    ack  = 1'b0;
    tick(4);

    // R2 request and ready latency
    want = 1'b1;
    tick(1);
    eq("R2 req rise", int'(req), 1);
    eq("R2 rdy_n before ack", int'(rdy_n), 1);
    ack = 1'b1;
    tick(2);
    eq("R2 rdy_n at 2", int'(rdy_n), 1);
    tick(1);
    eq("R2 rdy_n at 3", int'(rdy_n), 0);

    // R3 R5 fill until pause, both strobe edges used
    for (int k = 0; k < 5; k++) begin
      send(wfill(k));
      tick(2);
      if (k == 0) eq("R3 not yet visible", int'(pvld), 0);
      tick(1);
      if (k == 0) eq("R3 visible at 3", int'(pvld), 1);
      eq("R5 rdy_n vs free", int'(rdy_n), (k < 4) ? 0 : 1);
    end
    // R6 two words in flight after pause
    for (int k = 5; k < 7; k++) begin
      send(wfill(k));
      tick(3);
      eq("R6 still paused", int'(rdy_n), 1);
    end
    // R4 R5 drain three, ready returns when free exceeds headroom
    for (int k = 0; k < 3; k++) begin
      pop_expect("R4 order", wfill(k));
      eq("R5 rdy_n after pop", int'(rdy_n), (k < 2) ? 1 : 0);
    end

    // R9 host halt
    halt = 1'b1;
    tick(2);
    eq("R9 req before due", int'(req), 1);
    tick(1);
    eq("R9 req dropped", int'(req), 0);
    // R7 strobe after request dropped
    send(16'hDEAD);
    tick(4);
    for (int k = 3; k < 7; k++) pop_expect("R6 in-flight kept", wfill(k));
    eq("R7 late strobe ignored", int'(pvld), 0);
    want = 1'b0;
    halt = 1'b0;
    ack  = 1'b0;
    tick(2);
    eq("R10 tally not yet", int'(tvld), 0);
    tick(1);
    eq("R10 tally_vld", int'(tvld), 1);
    eq("R10 tally count", int'(tally), 7);
    tick(1);
    eq("R10 one-cycle pulse", int'(tvld), 0);
    tick(2);

    // R8 sweep of device-ended bursts
    for (int len = 1; len <= 4; len++) begin
      want = 1'b1;
      tick(1);
      eq("R2 req rise sweep", int'(req), 1);
      ack = 1'b1;
      tick(3);
      eq("R2 ready sweep", int'(rdy_n), 0);
      for (int k = 0; k < len - 1; k++) begin
        send(wsweep(len, k));
        tick(3);
      end
      send(wsweep(len, len - 1));
      want = 1'b0;
      tick(1);
      eq("R8 pause next cycle", int'(rdy_n), 1);
      tick(TRP - 1);
      eq("R8 req held in interval", int'(req), 1);
      tick(1);
      eq("R8 req dropped at interval", int'(req), 0);
      ack = 1'b0;
      tick(3);
      eq("R10 sweep tally_vld", int'(tvld), 1);
      eq("R10 sweep tally", int'(tally), len);
      for (int k = 0; k < len; k++) pop_expect("R3 R4 sweep order", wsweep(len, k));
      eq("R4 empty after drain", int'(pvld), 0);
      tick(2);
    end

    summary();
  end
endmodule